// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block lets a host reach the byte-wide internal registers of a two-wire bus controller through a single 64-bit command register. The host writes one command word. The word holds an operation code, a direction bit, a 3-bit register select and a 32-bit data field. Setting the top bit (the busy/valid flag) starts the access. The bridge then drives a one-cycle read or write strobe on the internal register bus. For a read, it loads the returned byte into the data field. It clears the valid flag when the access has finished. The host polls the register until the flag reads 0, and for a read it then takes the result from the low bits.

Only operation code 6 reaches the internal bus. Within that operation, select value 3 is shared. A write strobe on select 3 targets the clock-control register, and a read strobe on select 3 returns the status register. The controller behind the bus tells them apart by the strobe direction. Any other operation code finishes on the spot and touches nothing. While an access is in flight, the command register does not accept host writes.

Top module: `ind_reg_bridge`

## Requirements
- R1: After reset the command register reads all zero and neither internal strobe is active.
- R2: A host write of a word with bit 63 = 1 and bits [60:57] = 6 and bit 56 = 0, accepted while bit 63 of the register is 0, produces exactly one write strobe in the cycle after acceptance. During that strobe the select equals bits [34:32] and the write byte equals bits [7:0].
- R3: When such a word has bit 56 = 1, it produces exactly one read strobe instead. At completion the returned byte lands in bits [7:0], bits [31:8] become zero, and bits [62:32] keep their written values.
- R4: Bit 63 reads 1 from the edge that accepts an operation-6 access with bit 63 set. It is cleared on the second rising edge after that edge.
- R5: Select value 3 goes out as select 3 in both directions. A write there carries the host byte toward the clock-control register, and a read there returns the status register rather than the value just written.
- R6: Host writes arriving while bit 63 of the register is 1 are ignored. They do not alter the register and start no internal access.
- R7: A word with bit 63 = 1 and bits [60:57] ≠ 6 is stored at the acceptance edge with bit 63 already 0 and all other bits as written, including the data field. It produces no strobe.
- R8: A word written with bit 63 = 0 while idle is stored as written and starts no internal access.
- R9: After an operation-6 write access completes, the register equals the written word with bit 63 cleared, so the data field is unchanged.
- R10: The read and write strobes are never active together, and each strobe lasts a single cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr_en | input | 1 | Host write enable for the command register |
| host_wr_data | input | 64 | Command word written by the host |
| host_rd_data | output | 64 | Current contents of the command register |
| reg_sel | output | 3 | Internal register select |
| reg_rd | output | 1 | Internal read strobe, one cycle |
| reg_wr | output | 1 | Internal write strobe, one cycle |
| reg_wdata | output | 8 | Byte written to the internal register |
| reg_rdata | input | 8 | Byte returned by the internal register, sampled on the cycle after the read strobe |

## Verification
The bench builds the bridge with its default 8-bit internal register width. With that width the whole internal select space (eight values) can be swept in both directions, including the shared value 3 and the zeroing of bits [31:8] on reads. It also covers all sixteen operation codes with both direction bits, so each non-6 code is shown to bypass the internal bus. Host writes aimed at the busy window show whether a second command can slip into the strobe or capture cycle.

// File: rtl/ibr_pkg.sv
package ibr_pkg;

    localparam int CMD_W     = 64;
    localparam int DATA_LO   = 0;
    localparam int DATA_W    = 32;
    localparam int SEL_LO    = 32;
    localparam int SEL_W     = 3;
    localparam int DIR_BIT   = 56;
    localparam int OP_LO     = 57;
    localparam int OP_W      = 4;
    localparam int VALID_BIT = 63;
    localparam int EXT_OP    = 6;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_STROBE  = 2'd1,
        PH_CAPTURE = 2'd2
    } phase_e;

    typedef struct packed {
        phase_e ph;
        logic   rd;
    } seq_state_t;

    typedef struct packed {
        logic [CMD_W-1:0] cmd;
    } bridge_state_t;

endpackage

// File: rtl/ibr_cmd_decode.sv
module ibr_cmd_decode
    import ibr_pkg::*;
(
    input  logic [CMD_W-1:0] word,
    output logic             launch,
    output logic             bypass,
    output logic             is_read
);

    logic ext_op;

    always_comb begin
        ext_op  = (word[OP_LO +: OP_W] == OP_W'(EXT_OP));
        launch  = word[VALID_BIT] && ext_op;
        bypass  = word[VALID_BIT] && !ext_op;
        is_read = word[DIR_BIT];
    end

endmodule

// File: rtl/ibr_access_seq.sv
module ibr_access_seq
    import ibr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic start_rd,
    output logic strobe_rd,
    output logic strobe_wr,
    output logic done,
    output logic capture
);

    seq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        case (st_q.ph)
            PH_IDLE: begin
                if (start) begin
                    st_d.ph = PH_STROBE;
                    st_d.rd = start_rd;
                end
            end
            PH_STROBE:  st_d.ph = PH_CAPTURE;
            PH_CAPTURE: st_d.ph = PH_IDLE;
            default:    st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{ph: PH_IDLE, rd: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        strobe_rd = (st_q.ph == PH_STROBE) && st_q.rd;
        strobe_wr = (st_q.ph == PH_STROBE) && !st_q.rd;
        done      = (st_q.ph == PH_CAPTURE);
        capture   = done && st_q.rd;
    end

endmodule

// File: rtl/ind_reg_bridge.sv
module ind_reg_bridge
    import ibr_pkg::*;
#(
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_wr_en,
    input  logic [63:0]      host_wr_data,
    output logic [63:0]      host_rd_data,
    output logic [2:0]       reg_sel,
    output logic             reg_rd,
    output logic             reg_wr,
    output logic [REG_W-1:0] reg_wdata,
    input  logic [REG_W-1:0] reg_rdata
);

    bridge_state_t st_d, st_q;

    logic launch, bypass, is_read;
    logic accept, start;
    logic strobe_rd, strobe_wr, done, capture;

    ibr_cmd_decode u_dec (
        .word    (host_wr_data),
        .launch  (launch),
        .bypass  (bypass),
        .is_read (is_read)
    );

    ibr_access_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .start_rd  (is_read),
        .strobe_rd (strobe_rd),
        .strobe_wr (strobe_wr),
        .done      (done),
        .capture   (capture)
    );

    // A new command is taken only while no access is pending.
    always_comb begin
        accept = host_wr_en && !st_q.cmd[VALID_BIT];
        start  = accept && launch;
    end

    always_comb begin
        st_d = st_q;
        if (done) begin
            st_d.cmd[VALID_BIT] = 1'b0;
            if (capture) begin
                st_d.cmd[DATA_LO +: DATA_W] = DATA_W'(reg_rdata);
            end
        end else if (accept) begin
            st_d.cmd = host_wr_data;
            if (bypass) begin
                st_d.cmd[VALID_BIT] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{cmd: '0};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        host_rd_data = st_q.cmd;
        reg_sel      = st_q.cmd[SEL_LO +: SEL_W];
        reg_wdata    = st_q.cmd[DATA_LO +: REG_W];
        reg_rd       = strobe_rd;
        reg_wr       = strobe_wr;
    end

endmodule

// File: rtl/ibr_checker.sv
module ibr_checker
    import ibr_pkg::*;
#(
    parameter int REG_W = 8
) (
    input logic        clk,
    input logic        rst_n,
    input logic        host_wr_en,
    input logic [63:0] host_wr_data,
    input logic [63:0] host_rd_data,
    input logic        reg_rd,
    input logic        reg_wr
);

    logic strobe;
    logic ext_cmd;
    assign strobe  = reg_rd || reg_wr;
    assign ext_cmd = (host_wr_data[OP_LO +: OP_W] == OP_W'(EXT_OP));

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_rd && reg_wr)); // R10

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe); // R10

    AST_STROBE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> $past(host_wr_en && host_wr_data[VALID_BIT] && ext_cmd
                         && !host_rd_data[VALID_BIT])); // R2

    AST_BUSY_AT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> host_rd_data[VALID_BIT]); // R4

    AST_DONE_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> host_rd_data[VALID_BIT] ##1 !host_rd_data[VALID_BIT]); // R4

    AST_READ_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(host_rd_data[VALID_BIT]) && host_rd_data[DIR_BIT])
            |-> host_rd_data[DATA_W-1:REG_W] == '0); // R3

    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd_data[VALID_BIT] |=> $stable(host_rd_data[62:32])); // R6

    AST_BYPASS_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr_en && !host_rd_data[VALID_BIT] && host_wr_data[VALID_BIT] && !ext_cmd)
            |=> host_rd_data == {1'b0, $past(host_wr_data[62:0])}); // R7

endmodule

bind ind_reg_bridge ibr_checker #(.REG_W(REG_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_wr_en   (host_wr_en),
    .host_wr_data (host_wr_data),
    .host_rd_data (host_rd_data),
    .reg_rd       (reg_rd),
    .reg_wr       (reg_wr)
);

// File: tb/sim_ind_reg_bridge.sv
module sim_ind_reg_bridge;

    localparam logic [7:0] STAT_VAL = 8'hA5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr_en = 1'b0;
    logic [63:0] host_wr_data = '0;
    logic [63:0] host_rd_data;
    logic [2:0]  reg_sel;
    logic        reg_rd, reg_wr;
    logic [7:0]  reg_wdata;
    logic [7:0]  reg_rdata;

    int checks = 0;
    int failures = 0;
    int nstrobe = 0;
    int nboth = 0;
    int cyc = 0;

    logic [7:0] pmem [8];
    logic [7:0] exp_mem [8];

    always #2 clk = ~clk;

    ind_reg_bridge u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_wr_en   (host_wr_en),
        .host_wr_data (host_wr_data),
        .host_rd_data (host_rd_data),
        .reg_sel      (reg_sel),
        .reg_rd       (reg_rd),
        .reg_wr       (reg_wr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata)
    );

    // Model of the controller's register file behind the bridge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) pmem[i] <= 8'h00;
            reg_rdata <= 8'h00;
        end else begin
            if (reg_wr) pmem[reg_sel] <= reg_wdata;
            if (reg_rd) reg_rdata <= (reg_sel == 3'd3) ? STAT_VAL : pmem[reg_sel];
        end
    end

    always @(posedge clk) begin
        if (reg_rd || reg_wr) nstrobe++;
        if (reg_rd && reg_wr) nboth++;
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] mk(input bit v, input logic [3:0] op, input bit r,
                                       input logic [2:0] sel, input logic [31:0] data,
                                       input logic [20:0] misc);
        logic [63:0] w;
        w = '0;
        w[31:0]  = data;
        w[34:32] = sel;
        w[55:35] = misc;
        w[56]    = r;
        w[60:57] = op;
        w[62:61] = misc[1:0];
        w[63]    = v;
        return w;
    endfunction

    task automatic put(input logic [63:0] w);
        @(negedge clk);
        host_wr_en   = 1'b1;
        host_wr_data = w;
        @(negedge clk);
        host_wr_en   = 1'b0;
    endtask

    task automatic run_ext(input logic [2:0] sel, input bit r, input logic [31:0] data,
                           input logic [20:0] misc, input logic [7:0] expbyte,
                           input string tag);
        logic [63:0] w, e;
        int n0;
        w  = mk(1'b1, 4'd6, r, sel, data, misc);
        n0 = nstrobe;
        put(w);
        // Strobe cycle: first half-cycle after the acceptance edge.
        chk(r ? (reg_rd && !reg_wr) : (reg_wr && !reg_rd), {tag, " strobe dir"},
            {62'd0, reg_rd, reg_wr}, r ? 64'd2 : 64'd1);
        chk(reg_sel == sel, {tag, " select"}, 64'(reg_sel), 64'(sel));
        if (!r) chk(reg_wdata == data[7:0], {tag, " write byte"}, 64'(reg_wdata), 64'(data[7:0]));
        chk(host_rd_data[63] == 1'b1, "R4 busy in strobe cycle", 64'(host_rd_data[63]), 64'd1);
        @(negedge clk);
        chk(host_rd_data[63] == 1'b1 && !reg_rd && !reg_wr, "R4 busy in capture cycle",
            {host_rd_data[63], 61'd0, reg_rd, reg_wr}, {1'b1, 63'd0});
        @(negedge clk);
        e = w;
        e[63] = 1'b0;
        if (r) e[31:0] = {24'd0, expbyte};
        chk(host_rd_data == e, {tag, " result word"}, host_rd_data, e);
        chk(nstrobe == n0 + 1, "R10 one strobe per access", 64'(nstrobe - n0), 64'd1);
    endtask

    initial begin
        logic [63:0] w1, w2, e;
        int n0;
        repeat (3) @(negedge clk);
        // R1
        chk(host_rd_data == 64'd0 && !reg_rd && !reg_wr, "R1 reset state",
            host_rd_data, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(host_rd_data == 64'd0, "R1 idle after reset", host_rd_data, 64'd0);

        // R2, R9, R5: write every select value.
        for (int s = 0; s < 8; s++) begin
            logic [7:0] b;
            b = 8'((s * 37 + 11) & 255);
            exp_mem[s] = b;
            run_ext(3'(s), 1'b0, {24'h123456, b}, 21'(s * 4093 + 7),
                    8'h00, (s == 3) ? "R5 R9 write sel3" : "R2 R9 write");
        end
        // R3, R5: read every select value back.
        for (int s = 0; s < 8; s++) begin
            run_ext(3'(s), 1'b1, 32'hFFFF_FF00 | 32'(s), 21'(s * 777 + 3),
                    (s == 3) ? STAT_VAL : exp_mem[s],
                    (s == 3) ? "R5 R3 read status" : "R3 read");
        end

        // R7: sweep all non-extended operation codes in both directions.
        n0 = nstrobe;
        for (int op = 0; op < 16; op++) begin
            for (int r = 0; r < 2; r++) begin
                if (op != 6) begin
                    w1 = mk(1'b1, 4'(op), r[0], 3'(op & 7), 32'hC0DE_0000 | 32'(op * 16 + r),
                            21'(op * 99 + r));
                    put(w1);
                    e = w1;
                    e[63] = 1'b0;
                    chk(host_rd_data == e && !reg_rd && !reg_wr, "R7 bypass stored",
                        host_rd_data, e);
                end
            end
        end
        @(negedge clk);
        chk(nstrobe == n0, "R7 no strobe on bypass", 64'(nstrobe - n0), 64'd0);

        // R8: word with valid clear while idle.
        n0 = nstrobe;
        w1 = mk(1'b0, 4'd6, 1'b0, 3'd2, 32'h0000_0077, 21'h1ABCD);
        put(w1);
        chk(host_rd_data == w1, "R8 stored as written", host_rd_data, w1);
        repeat (2) @(negedge clk);
        chk(nstrobe == n0 && host_rd_data == w1, "R8 no access",
            64'(nstrobe - n0), 64'd0);

        // R6: second write during busy window is ignored.
        n0 = nstrobe;
        w1 = mk(1'b1, 4'd6, 1'b0, 3'd1, 32'h0000_003C, 21'h00321);
        w2 = mk(1'b1, 4'd6, 1'b0, 3'd2, 32'h0000_00C3, 21'h1F0F0);
        put(w1);
        host_wr_en   = 1'b1;
        host_wr_data = w2;
        @(negedge clk);
        chk(host_rd_data == w1, "R6 register held while busy", host_rd_data, w1);
        @(negedge clk);
        host_wr_en = 1'b0;
        e = w1;
        e[63] = 1'b0;
        chk(host_rd_data == e, "R6 first command completes", host_rd_data, e);
        chk(nstrobe == n0 + 1, "R6 no extra access", 64'(nstrobe - n0), 64'd1);
        exp_mem[1] = 8'h3C;
        run_ext(3'd2, 1'b1, 32'h0, 21'h0, exp_mem[2], "R6 sel2 untouched");
        run_ext(3'd1, 1'b1, 32'h0, 21'h0, exp_mem[1], "R6 sel1 updated");

        // R10: strobes never overlapped during the run.
        chk(nboth == 0, "R10 strobe exclusivity", 64'(nboth), 64'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=<50000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule